// File: doc/BRIEF.md
# Prefixed Shift, Rotate and Bit Unit

This block carries out the extended operation group of an 8-bit processor datapath on a single byte. One opcode byte selects a rotate (circular or through the carry), a shift (arithmetic or logical), a nibble swap, or a test, clear or set of one selected bit. The block returns the new byte, a write-back enable and the updated condition flags. The opcode's low three bits pass through so that the surrounding core can steer the write-back to the right operand. Register-file access and memory read-modify-write sequencing stay with the core.

A separate input marks the short accumulator-only rotate forms. These produce the same byte and carry as the extended rotates, but they always clear the zero flag. The core presents the opcode, operand, flags and that mode bit together. The results appear on the registered outputs one clock later, and a new operation can be issued on every cycle.

Opcode layout (these positions are decoded): bits 7:6 select the group, with 00 for shift/rotate, 01 for bit test, 10 for bit clear and 11 for bit set. Bits 5:3 hold the sub-operation or the bit index. Bits 2:0 hold the operand select. The shift/rotate sub-operation codes are 0 rotate left circular, 1 rotate right circular, 2 rotate left through carry, 3 rotate right through carry, 4 shift left arithmetic, 5 shift right arithmetic, 6 nibble swap and 7 shift right logical. The flag vector is ordered {Z, N, H, C} from bit 3 down to bit 0.

Top module: `pfx_unit`

## Requirements
- R1: While rst_n is low, result_o, wb_o, flags_o and sel_o are all zero.
- R2: Every output reflects the inputs captured at the preceding rising clock edge and holds its value until the next edge.
- R3: Circular rotates (codes 0 and 1) move the outgoing end bit into both the opposite end and C: bit 7 for a left rotate, bit 0 for a right rotate.
- R4: Through-carry rotates (codes 2 and 3) shift the incoming C into bit 0 (left) or bit 7 (right), and the new C is the bit shifted out.
- R5: Shift left arithmetic (4) fills bit 0 with 0 and sets C to the old bit 7. Shift right arithmetic (5) keeps bit 7. Shift right logical (7) fills bit 7 with 0. Both right shifts set C to the old bit 0.
- R6: Nibble swap (6) exchanges bits 7:4 with bits 3:0 and clears C.
- R7: Every operation in group 00 asserts wb_o, clears N and H, and sets Z exactly when the result is zero (R10 covers the exception).
- R8: Bit test (group 01) sets Z when the selected bit is 0, clears N, sets H, keeps C, deasserts wb_o and returns the operand unchanged.
- R9: Bit clear (group 10) and bit set (group 11) change only the selected bit, pass all four flags through unchanged and assert wb_o.
- R10: With acc_form_i high, sub-operation codes 0 to 3 in group 00 give the same byte and C as in R3 and R4, but Z is 0. For any other opcode acc_form_i has no effect on any output.
- R11: sel_o equals opcode bits 2:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_form_i | input | 1 | Marks the accumulator-only rotate form (Z forced to 0) |
| opcode_i | input | 8 | Extended opcode byte |
| opnd_i | input | 8 | Operand byte |
| flags_i | input | 4 | Incoming flags {Z, N, H, C} |
| result_o | output | 8 | Resulting byte |
| wb_o | output | 1 | Result should be written back |
| flags_o | output | 4 | New flags {Z, N, H, C} |
| sel_o | output | 3 | Operand select from opcode bits 2:0 |

## Verification
The assertions assume that every input is free of X, is held steady around each rising edge, and is sampled with a one-cycle offset from the previous edge. They also assume that the reset is released only between edges. The stimulus changes the inputs only on falling edges. It walks every opcode against every operand value and derives the incoming flags and the mode bit from bits of those two bytes. This way both carry values and both mode values meet every sub-operation and every bit index. The stimulus keeps the reset low only in windows that it checks separately.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
    localparam int unsigned DW     = 8;
    localparam int unsigned HALF_W = DW / 2;
    localparam int unsigned IDX_W  = $clog2(DW);
    localparam int unsigned OP_W   = 8;
    localparam int unsigned SEL_W  = 3;
    localparam int unsigned FLG_W  = 4;

    typedef enum logic [1:0] {
        GRP_SHIFT = 2'd0,
        GRP_TEST  = 2'd1,
        GRP_CLR   = 2'd2,
        GRP_SET   = 2'd3
    } grp_e;

    typedef enum logic [2:0] {
        SH_ROL_CIRC = 3'd0,
        SH_ROR_CIRC = 3'd1,
        SH_ROL_THRU = 3'd2,
        SH_ROR_THRU = 3'd3,
        SH_SLA      = 3'd4,
        SH_SRA      = 3'd5,
        SH_SWAP     = 3'd6,
        SH_SRL      = 3'd7
    } sh_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flags_t;

    typedef struct packed {
        logic [DW-1:0]    res;
        logic             wb;
        flags_t           flg;
        logic [SEL_W-1:0] sel;
    } out_t;
endpackage

// File: rtl/pfx_shift_unit.sv
module pfx_shift_unit
    import pfx_pkg::*;
(
    input  sh_e           sub_i,
    input  logic [DW-1:0] din_i,
    input  logic          cin_i,
    output logic [DW-1:0] dout_o,
    output logic          cout_o
);
    logic msb, lsb;

    assign msb = din_i[DW-1];
    assign lsb = din_i[0];

    always_comb begin
        dout_o = din_i;
        cout_o = 1'b0;
        case (sub_i)
            SH_ROL_CIRC: begin
                dout_o = {din_i[DW-2:0], msb};
                cout_o = msb;
            end
            SH_ROR_CIRC: begin
                dout_o = {lsb, din_i[DW-1:1]};
                cout_o = lsb;
            end
            SH_ROL_THRU: begin
                dout_o = {din_i[DW-2:0], cin_i};
                cout_o = msb;
            end
            SH_ROR_THRU: begin
                dout_o = {cin_i, din_i[DW-1:1]};
                cout_o = lsb;
            end
            SH_SLA: begin
                dout_o = {din_i[DW-2:0], 1'b0};
                cout_o = msb;
            end
            SH_SRA: begin
                dout_o = {msb, din_i[DW-1:1]};
                cout_o = lsb;
            end
            SH_SWAP: begin
                dout_o = {din_i[HALF_W-1:0], din_i[DW-1:HALF_W]};
                cout_o = 1'b0;
            end
            SH_SRL: begin
                dout_o = {1'b0, din_i[DW-1:1]};
                cout_o = lsb;
            end
            default: begin
                dout_o = din_i;
                cout_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/pfx_bit_unit.sv
module pfx_bit_unit
    import pfx_pkg::*;
(
    input  logic [IDX_W-1:0] idx_i,
    input  logic [DW-1:0]    din_i,
    output logic             bit_o,
    output logic [DW-1:0]    clr_o,
    output logic [DW-1:0]    set_o
);
    logic [DW-1:0] mask;

    for (genvar g = 0; g < DW; g++) begin : g_mask
        assign mask[g] = (idx_i == IDX_W'(g));
    end

    assign bit_o = |(din_i & mask);
    assign clr_o = din_i & ~mask;
    assign set_o = din_i | mask;
endmodule

// File: rtl/pfx_unit.sv
module pfx_unit
    import pfx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_form_i,
    input  logic [OP_W-1:0]  opcode_i,
    input  logic [DW-1:0]    opnd_i,
    input  logic [FLG_W-1:0] flags_i,
    output logic [DW-1:0]    result_o,
    output logic             wb_o,
    output logic [FLG_W-1:0] flags_o,
    output logic [SEL_W-1:0] sel_o
);
    grp_e             grp;
    sh_e              sub;
    logic [IDX_W-1:0] idx;
    flags_t           fin;
    logic [DW-1:0]    sh_res, clr_res, set_res;
    logic             sh_c, tst_bit, acc_rot;
    out_t             out_d, out_q;

    assign grp     = grp_e'(opcode_i[7:6]);
    assign sub     = sh_e'(opcode_i[5:3]);
    assign idx     = opcode_i[3 +: IDX_W];
    assign fin     = flags_t'(flags_i);
    assign acc_rot = acc_form_i && !opcode_i[5];

    pfx_shift_unit u_shift (
        .sub_i  (sub),
        .din_i  (opnd_i),
        .cin_i  (fin.c),
        .dout_o (sh_res),
        .cout_o (sh_c)
    );

    pfx_bit_unit u_bit (
        .idx_i (idx),
        .din_i (opnd_i),
        .bit_o (tst_bit),
        .clr_o (clr_res),
        .set_o (set_res)
    );

    always_comb begin
        out_d     = '0;
        out_d.sel = opcode_i[SEL_W-1:0];
        case (grp)
            GRP_SHIFT: begin
                out_d.res   = sh_res;
                out_d.wb    = 1'b1;
                out_d.flg.z = (sh_res == '0) && !acc_rot;
                out_d.flg.n = 1'b0;
                out_d.flg.h = 1'b0;
                out_d.flg.c = sh_c;
            end
            GRP_TEST: begin
                out_d.res   = opnd_i;
                out_d.wb    = 1'b0;
                out_d.flg.z = !tst_bit;
                out_d.flg.n = 1'b0;
                out_d.flg.h = 1'b1;
                out_d.flg.c = fin.c;
            end
            GRP_CLR: begin
                out_d.res = clr_res;
                out_d.wb  = 1'b1;
                out_d.flg = fin;
            end
            GRP_SET: begin
                out_d.res = set_res;
                out_d.wb  = 1'b1;
                out_d.flg = fin;
            end
            default: begin
                out_d.res = opnd_i;
                out_d.wb  = 1'b0;
                out_d.flg = fin;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign result_o = out_q.res;
    assign wb_o     = out_q.wb;
    assign flags_o  = out_q.flg;
    assign sel_o    = out_q.sel;
endmodule

// File: rtl/pfx_unit_chk.sv
module pfx_unit_chk
    import pfx_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             acc_form_i,
    input logic [OP_W-1:0]  opcode_i,
    input logic [DW-1:0]    opnd_i,
    input logic [FLG_W-1:0] flags_i,
    input logic [DW-1:0]    result_o,
    input logic             wb_o,
    input logic [FLG_W-1:0] flags_o,
    input logic [SEL_W-1:0] sel_o
);
    AST_SEL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> sel_o == $past(opcode_i[SEL_W-1:0])); // R11

    AST_SHIFT_NH_WB: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(opcode_i[7:6]) == 2'b00 |-> flags_o[2:1] == 2'b00 && wb_o); // R7

    AST_TEST_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(opcode_i[7:6]) == 2'b01 |-> !wb_o && flags_o[1] && !flags_o[2]
            && flags_o[0] == $past(flags_i[0]) && result_o == $past(opnd_i)); // R8

    AST_RS_FLAGS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(opcode_i[7]) |-> flags_o == $past(flags_i) && wb_o); // R9

    AST_RS_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(opcode_i[7]) |-> $countones(result_o ^ $past(opnd_i)) <= 1); // R9

    AST_ACC_ZERO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(acc_form_i) && $past(opcode_i[7:5]) == 3'b000 |-> !flags_o[3]); // R10

    AST_SWAP_NO_C: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(opcode_i[7:3]) == 5'b00110 |-> !flags_o[0]); // R6
endmodule

bind pfx_unit pfx_unit_chk u_chk (.*);

// File: tb/sim_pfx_unit.sv
module sim_pfx_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_form_i = 1'b0;
    logic [7:0] opcode_i = '0;
    logic [7:0] opnd_i = '0;
    logic [3:0] flags_i = '0;
    logic [7:0] result_o;
    logic       wb_o;
    logic [3:0] flags_o;
    logic [2:0] sel_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pfx_unit u0 (
        .clk(clk), .rst_n(rst_n), .acc_form_i(acc_form_i), .opcode_i(opcode_i),
        .opnd_i(opnd_i), .flags_i(flags_i), .result_o(result_o), .wb_o(wb_o),
        .flags_o(flags_o), .sel_o(sel_o)
    );

    // expected {result[15:8], wb[7], unused, sel[6:4], flags[3:0]} packed as 16 bits
    function automatic logic [15:0] model(input int op, input int a, input int f, input int acc);
        int grp, s, c, r, co, z, wb, fo;
        grp = op / 64; s = (op / 8) % 8; c = f % 2;
        r = a; wb = 1; fo = f; co = 0;
        if (grp == 0) begin
            case (s)
                0: begin r = (a * 2) % 256 + a / 128; co = a / 128; end
                1: begin r = a / 2 + (a % 2) * 128; co = a % 2; end
                2: begin r = (a * 2) % 256 + c; co = a / 128; end
                3: begin r = a / 2 + c * 128; co = a % 2; end
                4: begin r = (a * 2) % 256; co = a / 128; end
                5: begin r = a / 2 + (a / 128) * 128; co = a % 2; end
                6: begin r = (a % 16) * 16 + a / 16; co = 0; end
                default: begin r = a / 2; co = a % 2; end
            endcase
            z = (r == 0 && !(acc != 0 && s < 4)) ? 1 : 0;
            fo = z * 8 + co;
        end else if (grp == 1) begin
            wb = 0;
            fo = (((a >> s) % 2) == 0 ? 8 : 0) + 2 + c;
        end else if (grp == 2) begin
            r = a - (((a >> s) % 2) << s);
        end else begin
            r = a - (((a >> s) % 2) << s) + (1 << s);
        end
        model = {r[7:0], wb[0], 1'b0, 2'(0), fo[3:0]};
    endfunction

    function automatic string tag_of(input int op, input int acc);
        int grp, s;
        grp = op / 64; s = (op / 8) % 8;
        if (grp == 1) return "R8 R11";
        if (grp >= 2) return "R9 R11";
        if (acc != 0 && s < 4) return "R10 R7";
        if (s < 2) return "R3 R7";
        if (s < 4) return "R4 R7";
        if (s == 6) return "R6 R7";
        return "R5 R7";
    endfunction

    task automatic check_out(input string tag, input logic [7:0] er, input logic ew,
                             input logic [3:0] ef, input logic [2:0] es);
        n_chk++;
        if (result_o !== er || wb_o !== ew || flags_o !== ef || sel_o !== es) begin
            n_bad++;
            $display("FAIL %s: got res=%02h wb=%0b flg=%04b sel=%0d, want res=%02h wb=%0b flg=%04b sel=%0d",
                     tag, result_o, wb_o, flags_o, sel_o, er, ew, ef, es);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout, want completion");
        finish_run();
    end

    initial begin
        logic [15:0] prev;
        logic        have_prev;
        have_prev = 1'b0;
        prev = '0;
        // R1: outputs held at zero during reset even with busy inputs
        opcode_i = 8'hFF; opnd_i = 8'h5A; flags_i = 4'hF; acc_form_i = 1'b1;
        repeat (3) @(negedge clk);
        check_out("R1", 8'h00, 1'b0, 4'h0, 3'd0);
        rst_n = 1'b1;
        for (int i = 0; i < 65536; i++) begin
            int op, a, f, acc;
            logic [15:0] exp_v;
            op = i / 256; a = i % 256;
            f = ((op ^ (a >> 1)) % 2) * 8 + (((a ^ (op >> 3)) % 2)) * 4
              + (((op >> 1) ^ (a >> 5)) % 2) * 2 + (((a >> 7) ^ (op >> 4) ^ (a >> 2)) % 2);
            acc = ((a >> 3) ^ op) % 2;
            opcode_i = 8'(op); opnd_i = 8'(a); flags_i = 4'(f); acc_form_i = acc[0];
            // R2: new inputs must not reach outputs before the edge
            #1;
            if (have_prev)
                check_out("R2", prev[15:8], prev[7], prev[3:0], prev[6:4]);
            exp_v = model(op, a, f, acc);
            exp_v[6:4] = 3'(op % 8);
            @(negedge clk);
            check_out(tag_of(op, acc), exp_v[15:8], exp_v[7], exp_v[3:0], exp_v[6:4]);
            prev = exp_v;
            have_prev = 1'b1;
        end
        // R1: asynchronous reset mid-run clears outputs
        opcode_i = 8'h00; opnd_i = 8'h80;
        @(negedge clk);
        rst_n = 1'b0;
        #2;
        check_out("R1", 8'h00, 1'b0, 4'h0, 3'd0);
        @(negedge clk);
        check_out("R1", 8'h00, 1'b0, 4'h0, 3'd0);
        finish_run();
    end
endmodule